// File: doc/BRIEF.md
# Event-Counting Interrupt Prescaler

This block sits next to a PWM time-base counter. It turns selected counter events into one latched interrupt request after a programmable number of occurrences. It decodes one event source from the counter strobes: counter at zero, counter at period, and up-count or down-count compare hits on four compare channels. It then counts that event in one of two prescalers. The short prescaler is 2 bits wide and has a period of 1 to 3. The wide prescaler is 4 bits wide and has a period of 1 to 15. When the active count reaches its period, the block issues a one-cycle interrupt pulse and sets a sticky flag. Software clears the flag by writing one.

A software force advances the active counter as if one event had occurred. The wide counter can also be preloaded with a programmed initial value, either on the sync input or on a software init force. The block has no streaming data path. Every port is a plain level or a one-cycle strobe sampled on the rising clock edge, so the block has no valid/ready handshake and no back-pressure. Reset is asynchronous and active low.

Top module: `evt_int_prescaler`

## Requirements
- R1: Source select `cfg_src_sel` uses these codes. 3'b001 counts `evt_zero` and 3'b010 counts `evt_period`. Codes 3'b000 and 3'b011 count nothing. A strobe that is not selected leaves the counters unchanged.
- R2: The compare codes are: 3'b100 up-count hit on the low channel, 3'b101 down-count hit on the low channel, 3'b110 up-count hit on the high channel, 3'b111 down-count hit on the high channel. With `cfg_grp_alt`=0 the low channel is bit 0 (A) and the high channel is bit 1 (B). With `cfg_grp_alt`=1 they are bit 2 (C) and bit 3 (D) of `cmp_up_hit`/`cmp_dn_hit`.
- R3: A `sw_force` strobe advances the active counter by one, exactly like a selected event.
- R4: When the active period is 0, the active counter holds. Neither events nor `sw_force` change it.
- R5: With `cfg_ps_wide`=0, `short_cnt` counts events up to `cfg_short_prd` (1..3). The edge after the count reaches the period produces the pulse.
- R6: With `cfg_ps_wide`=1, `wide_cnt` counts up to `cfg_wide_prd` (1..15). The inactive counter holds its value.
- R7: When `cfg_init_en`=1, a `sync_in` or `sw_init_force` strobe loads `cfg_init_val` into `wide_cnt`. This load takes priority over a same-cycle event. When `cfg_init_en`=0, both strobes are ignored.
- R8: A count at or above a nonzero active period, with `irq_flag` clear and `cfg_int_en`=1, produces a one-cycle `irq_pulse` on the next edge. That edge also sets `irq_flag` and resets the counter to 0. With `cfg_int_en`=0 the counter holds at the period and no pulse is issued.
- R9: While `irq_flag` is set, no pulse is issued and a counter at its period holds there. `flag_clr` clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R10: After reset, both counters are 0, `irq_flag` is 0 and `irq_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_zero | input | 1 | Strobe: time-base counter at zero |
| evt_period | input | 1 | Strobe: time-base counter at period |
| cmp_up_hit | input | 4 | Up-count compare hit strobes, channels A..D in bits 0..3 |
| cmp_dn_hit | input | 4 | Down-count compare hit strobes, channels A..D in bits 0..3 |
| sync_in | input | 1 | Sync strobe that triggers a wide-counter preload |
| cfg_int_en | input | 1 | Interrupt enable |
| cfg_src_sel | input | 3 | Event source code |
| cfg_grp_alt | input | 1 | Selects compare channels C/D in place of A/B |
| cfg_ps_wide | input | 1 | 1 selects the wide prescaler, 0 the short one |
| cfg_short_prd | input | 2 | Short prescaler period (0 disables it) |
| cfg_wide_prd | input | 4 | Wide prescaler period (0 disables it) |
| cfg_init_val | input | 4 | Preload value for the wide counter |
| cfg_init_en | input | 1 | Enables the wide-counter preload |
| sw_force | input | 1 | Software event strobe |
| sw_init_force | input | 1 | Software preload strobe |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_flag | output | 1 | Latched interrupt flag |
| short_cnt | output | 2 | Short prescaler count |
| wide_cnt | output | 4 | Wide prescaler count |

## Verification
The bench feeds strobes that the current code does not select, including the two dead codes, and strobes on the wrong compare group. A faulty decoder would advance the count on these. It also sets a zero period and fires a software force, which a design that counted anyway would let through. It drives a preload and an event in the same cycle, where a wrong priority would leave one count above the initial value. It also holds the flag set, or the enable low, while the count sits at its period. A design that got this wrong would issue a second pulse or let the counter run past its period. A set and a clear that coincide show whether the set wins.

// File: rtl/evtp_pkg.sv
package evtp_pkg;
  typedef enum logic [2:0] {
    SRC_OFF_A = 3'b000,
    SRC_ZERO  = 3'b001,
    SRC_PRD   = 3'b010,
    SRC_OFF_B = 3'b011,
    SRC_UP_LO = 3'b100,
    SRC_DN_LO = 3'b101,
    SRC_UP_HI = 3'b110,
    SRC_DN_HI = 3'b111
  } src_e;
endpackage

// File: rtl/evtp_src_mux.sv
module evtp_src_mux #(
  parameter int NUM_CMP = 4
) (
  input  logic               evt_zero,
  input  logic               evt_period,
  input  logic [NUM_CMP-1:0] cmp_up_hit,
  input  logic [NUM_CMP-1:0] cmp_dn_hit,
  input  logic [2:0]         src_sel,
  input  logic               grp_alt,
  output logic               evt_hit
);
  import evtp_pkg::*;
  localparam int HALF  = NUM_CMP / 2;
  localparam int IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

  logic [IDX_W-1:0] lo_idx, hi_idx;
  src_e             code;

  always_comb begin
    lo_idx = grp_alt ? IDX_W'(HALF)     : IDX_W'(0);
    hi_idx = grp_alt ? IDX_W'(HALF + 1) : IDX_W'(1);
    code   = src_e'(src_sel);
    case (code)
      SRC_ZERO:  evt_hit = evt_zero;
      SRC_PRD:   evt_hit = evt_period;
      SRC_UP_LO: evt_hit = cmp_up_hit[lo_idx];
      SRC_DN_LO: evt_hit = cmp_dn_hit[lo_idx];
      SRC_UP_HI: evt_hit = cmp_up_hit[hi_idx];
      SRC_DN_HI: evt_hit = cmp_dn_hit[hi_idx];
      default:   evt_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/evtp_counter.sv
module evtp_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [W-1:0] prd,
  input  logic         evt,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         fire,
  output logic [W-1:0] cnt,
  output logic         reached
);
  logic prd_on;

  assign prd_on  = (prd != '0);
  assign reached = prd_on && (cnt >= prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (active && prd_on) begin
      if (fire) begin
        cnt <= '0;
      end else if (evt && (cnt < prd)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_int_prescaler.sv
module evt_int_prescaler #(
  parameter int SHORT_W = 2,
  parameter int WIDE_W  = 4,
  parameter int NUM_CMP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_zero,
  input  logic               evt_period,
  input  logic [NUM_CMP-1:0] cmp_up_hit,
  input  logic [NUM_CMP-1:0] cmp_dn_hit,
  input  logic               sync_in,
  input  logic               cfg_int_en,
  input  logic [2:0]         cfg_src_sel,
  input  logic               cfg_grp_alt,
  input  logic               cfg_ps_wide,
  input  logic [SHORT_W-1:0] cfg_short_prd,
  input  logic [WIDE_W-1:0]  cfg_wide_prd,
  input  logic [WIDE_W-1:0]  cfg_init_val,
  input  logic               cfg_init_en,
  input  logic               sw_force,
  input  logic               sw_init_force,
  input  logic               flag_clr,
  output logic               irq_pulse,
  output logic               irq_flag,
  output logic [SHORT_W-1:0] short_cnt,
  output logic [WIDE_W-1:0]  wide_cnt
);
  logic sel_hit, evt_any;
  logic short_reached, wide_reached, act_reached;
  logic fire, wide_load;

  evtp_src_mux #(.NUM_CMP(NUM_CMP)) src_i (
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .cmp_up_hit (cmp_up_hit),
    .cmp_dn_hit (cmp_dn_hit),
    .src_sel    (cfg_src_sel),
    .grp_alt    (cfg_grp_alt),
    .evt_hit    (sel_hit)
  );

  assign evt_any     = sel_hit | sw_force;
  assign wide_load   = cfg_init_en & (sync_in | sw_init_force);
  assign act_reached = cfg_ps_wide ? wide_reached : short_reached;
  assign fire        = act_reached & ~irq_flag & cfg_int_en;

  evtp_counter #(.W(SHORT_W)) short_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (~cfg_ps_wide),
    .prd      (cfg_short_prd),
    .evt      (evt_any),
    .load     (1'b0),
    .load_val ({SHORT_W{1'b0}}),
    .fire     (fire),
    .cnt      (short_cnt),
    .reached  (short_reached)
  );

  evtp_counter #(.W(WIDE_W)) wide_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (cfg_ps_wide),
    .prd      (cfg_wide_prd),
    .evt      (evt_any),
    .load     (wide_load),
    .load_val (cfg_init_val),
    .fire     (fire),
    .cnt      (wide_cnt),
    .reached  (wide_reached)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (fire) irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/evtp_checker.sv
module evtp_checker #(
  parameter int SHORT_W = 2,
  parameter int WIDE_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_pulse,
  input logic               irq_flag,
  input logic               flag_clr,
  input logic               cfg_int_en,
  input logic               cfg_ps_wide,
  input logic [SHORT_W-1:0] cfg_short_prd,
  input logic [WIDE_W-1:0]  cfg_wide_prd,
  input logic               cfg_init_en,
  input logic [WIDE_W-1:0]  cfg_init_val,
  input logic               sync_in,
  input logic               sw_init_force,
  input logic [SHORT_W-1:0] short_cnt,
  input logic [WIDE_W-1:0]  wide_cnt
);
  logic init_req;
  assign init_req = cfg_init_en && (sync_in || sw_init_force);

  assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);

  assert_pulse_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_int_en |=> !irq_pulse);

  assert_no_pulse_while_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |=> !irq_pulse);

  assert_flag_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && flag_clr) |=> !irq_flag);

  assert_short_zero_prd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ps_wide && cfg_short_prd == '0) |=> $stable(short_cnt));

  assert_wide_zero_prd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ps_wide && cfg_wide_prd == '0 && !init_req) |=> $stable(wide_cnt));

  assert_inactive_short_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ps_wide |=> $stable(short_cnt));

  assert_init_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (wide_cnt == $past(cfg_init_val)));
endmodule

bind evt_int_prescaler evtp_checker #(.SHORT_W(SHORT_W), .WIDE_W(WIDE_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_pulse     (irq_pulse),
  .irq_flag      (irq_flag),
  .flag_clr      (flag_clr),
  .cfg_int_en    (cfg_int_en),
  .cfg_ps_wide   (cfg_ps_wide),
  .cfg_short_prd (cfg_short_prd),
  .cfg_wide_prd  (cfg_wide_prd),
  .cfg_init_en   (cfg_init_en),
  .cfg_init_val  (cfg_init_val),
  .sync_in       (sync_in),
  .sw_init_force (sw_init_force),
  .short_cnt     (short_cnt),
  .wide_cnt      (wide_cnt)
);

// File: tb/evt_int_prescaler_tb_top.sv
`timescale 1ns/1ps
module evt_int_prescaler_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       evt_zero = 0, evt_period = 0, sync_in = 0;
  logic [3:0] cmp_up_hit = '0, cmp_dn_hit = '0;
  logic       cfg_int_en = 0, cfg_grp_alt = 0, cfg_ps_wide = 0, cfg_init_en = 0;
  logic [2:0] cfg_src_sel = '0;
  logic [1:0] cfg_short_prd = '0;
  logic [3:0] cfg_wide_prd = '0, cfg_init_val = '0;
  logic       sw_force = 0, sw_init_force = 0, flag_clr = 0;
  logic       irq_pulse, irq_flag;
  logic [1:0] short_cnt;
  logic [3:0] wide_cnt;

  evt_int_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .evt_zero(evt_zero), .evt_period(evt_period),
    .cmp_up_hit(cmp_up_hit), .cmp_dn_hit(cmp_dn_hit), .sync_in(sync_in),
    .cfg_int_en(cfg_int_en), .cfg_src_sel(cfg_src_sel), .cfg_grp_alt(cfg_grp_alt),
    .cfg_ps_wide(cfg_ps_wide), .cfg_short_prd(cfg_short_prd), .cfg_wide_prd(cfg_wide_prd),
    .cfg_init_val(cfg_init_val), .cfg_init_en(cfg_init_en), .sw_force(sw_force),
    .sw_init_force(sw_init_force), .flag_clr(flag_clr), .irq_pulse(irq_pulse),
    .irq_flag(irq_flag), .short_cnt(short_cnt), .wide_cnt(wide_cnt)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_short = 0, m_wide = 0, m_flag = 0, m_pulse = 0;
  always @(posedge clk) begin : ref_model
    int ev, lo, hi, prd, cnt, fire;
    if (!rst_n) begin
      m_short = 0; m_wide = 0; m_flag = 0; m_pulse = 0;
    end else begin
      lo = cfg_grp_alt ? 2 : 0;
      hi = cfg_grp_alt ? 3 : 1;
      case (cfg_src_sel)
        3'd1: ev = evt_zero;
        3'd2: ev = evt_period;
        3'd4: ev = cmp_up_hit[lo];
        3'd5: ev = cmp_dn_hit[lo];
        3'd6: ev = cmp_up_hit[hi];
        3'd7: ev = cmp_dn_hit[hi];
        default: ev = 0;
      endcase
      if (sw_force) ev = 1;
      prd  = cfg_ps_wide ? int'(cfg_wide_prd) : int'(cfg_short_prd);
      cnt  = cfg_ps_wide ? m_wide : m_short;
      fire = (prd != 0 && cnt >= prd && m_flag == 0 && cfg_int_en) ? 1 : 0;
      if (prd != 0) begin
        if (fire != 0) cnt = 0;
        else if (ev != 0 && cnt < prd) cnt = cnt + 1;
      end
      if (cfg_ps_wide) m_wide = cnt; else m_short = cnt;
      if (cfg_init_en && (sync_in || sw_init_force)) m_wide = int'(cfg_init_val);
      m_pulse = fire;
      if (fire != 0) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 model pulse", int'(irq_pulse), m_pulse);
      chk("R9 model flag", int'(irq_flag), m_flag);
      chk("R5 model short_cnt", int'(short_cnt), m_short);
      chk("R6 model wide_cnt", int'(wide_cnt), m_wide);
    end
  end

  task automatic set_sig(int which, logic v);
    case (which)
      0: evt_zero = v;
      1: evt_period = v;
      2, 3, 4, 5: cmp_up_hit[which-2] = v;
      6, 7, 8, 9: cmp_dn_hit[which-6] = v;
      10: sw_force = v;
      11: sync_in = v;
      12: sw_init_force = v;
      default: flag_clr = v;
    endcase
  endtask

  task automatic strobe(int which);
    @(negedge clk); set_sig(which, 1'b1);
    @(negedge clk); set_sig(which, 1'b0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cfg_int_en = 0; cfg_grp_alt = 0; cfg_ps_wide = 0; cfg_init_en = 0;
    cfg_src_sel = '0; cfg_short_prd = '0; cfg_wide_prd = '0; cfg_init_val = '0;
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  initial begin
    do_reset();
    chk("R10 reset flag", int'(irq_flag), 0);
    chk("R10 reset pulse", int'(irq_pulse), 0);
    chk("R10 reset short", int'(short_cnt), 0);
    chk("R10 reset wide", int'(wide_cnt), 0);

    // R1 source decode
    cfg_src_sel = 3'b001; cfg_short_prd = 2'd3;
    strobe(0); strobe(0);
    chk("R1 zero counted", int'(short_cnt), 2);
    strobe(1);
    chk("R1 period ignored", int'(short_cnt), 2);
    cfg_src_sel = 3'b000; strobe(0); strobe(1); strobe(2);
    chk("R1 code 000 dead", int'(short_cnt), 2);
    cfg_src_sel = 3'b011; strobe(0); strobe(1); strobe(6);
    chk("R1 code 011 dead", int'(short_cnt), 2);
    cfg_src_sel = 3'b010; strobe(1);
    chk("R1 period counted", int'(short_cnt), 3);

    // R2 compare codes and group swap
    do_reset();
    cfg_src_sel = 3'b100; cfg_short_prd = 2'd3;
    strobe(2);
    chk("R2 up A counted", int'(short_cnt), 1);
    strobe(4); strobe(6);
    chk("R2 up C and dn A ignored", int'(short_cnt), 1);
    cfg_grp_alt = 1;
    strobe(4);
    chk("R2 up C counted", int'(short_cnt), 2);
    strobe(2);
    chk("R2 up A ignored alt", int'(short_cnt), 2);
    cfg_src_sel = 3'b111;
    strobe(9);
    chk("R2 dn D counted", int'(short_cnt), 3);

    // R3 software force, R4 zero period
    do_reset();
    cfg_src_sel = 3'b001; cfg_short_prd = 2'd3;
    strobe(10);
    chk("R3 force counted", int'(short_cnt), 1);
    cfg_short_prd = 2'd0;
    strobe(10); strobe(0);
    chk("R4 short disabled", int'(short_cnt), 1);
    cfg_ps_wide = 1; cfg_wide_prd = 4'd0;
    strobe(10); strobe(0);
    chk("R4 wide disabled", int'(wide_cnt), 0);

    // R5 short prescaler with pulse
    do_reset();
    cfg_src_sel = 3'b001; cfg_short_prd = 2'd3; cfg_int_en = 1;
    strobe(0); strobe(0);
    chk("R5 two events", int'(short_cnt), 2);
    chk("R5 no early pulse", int'(irq_flag), 0);
    strobe(0);
    chk("R5 reached period", int'(short_cnt), 3);
    idle(1);
    chk("R8 pulse issued", int'(irq_pulse), 1);
    chk("R8 flag set", int'(irq_flag), 1);
    chk("R8 counter reset", int'(short_cnt), 0);
    idle(1);
    chk("R8 pulse one cycle", int'(irq_pulse), 0);

    // R6 wide prescaler
    do_reset();
    cfg_src_sel = 3'b001; cfg_ps_wide = 1; cfg_wide_prd = 4'd15; cfg_int_en = 1;
    for (int i = 0; i < 14; i++) strobe(0);
    chk("R6 fourteen events", int'(wide_cnt), 14);
    chk("R6 no flag yet", int'(irq_flag), 0);
    strobe(0); idle(1);
    chk("R6 pulse at 15", int'(irq_pulse), 1);
    chk("R6 wide reset", int'(wide_cnt), 0);
    chk("R6 short held", int'(short_cnt), 0);

    // R7 preload
    do_reset();
    cfg_ps_wide = 1; cfg_wide_prd = 4'd15; cfg_init_val = 4'd9;
    strobe(11);
    chk("R7 sync ignored when disabled", int'(wide_cnt), 0);
    cfg_init_en = 1;
    strobe(11);
    chk("R7 sync loads", int'(wide_cnt), 9);
    cfg_src_sel = 3'b001;
    @(negedge clk); sync_in = 1; evt_zero = 1;
    @(negedge clk); sync_in = 0; evt_zero = 0;
    chk("R7 load beats event", int'(wide_cnt), 9);
    cfg_init_val = 4'd5;
    strobe(12);
    chk("R7 sw init loads", int'(wide_cnt), 5);

    // R8 enable gating
    do_reset();
    cfg_src_sel = 3'b001; cfg_short_prd = 2'd1;
    strobe(0);
    chk("R8 count at period", int'(short_cnt), 1);
    idle(1); chk("R8 no pulse disabled", int'(irq_pulse), 0);
    idle(1); chk("R8 no pulse disabled b", int'(irq_pulse), 0);
    chk("R8 held at period", int'(short_cnt), 1);
    cfg_int_en = 1;
    idle(1);
    chk("R8 pulse after enable", int'(irq_pulse), 1);

    // R9 flag blocking and clear
    strobe(0);
    chk("R9 counts to period", int'(short_cnt), 1);
    idle(1); chk("R9 no pulse flag set", int'(irq_pulse), 0);
    idle(1); chk("R9 no pulse flag set b", int'(irq_pulse), 0);
    strobe(0);
    chk("R9 holds at period", int'(short_cnt), 1);
    strobe(13);
    chk("R9 flag cleared", int'(irq_flag), 0);
    idle(1);
    chk("R9 pulse after clear", int'(irq_pulse), 1);
    strobe(13);
    @(negedge clk); evt_zero = 1;
    @(negedge clk); evt_zero = 0; flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk("R9 set wins over clear", int'(irq_flag), 1);
    chk("R9 pulse with clear", int'(irq_pulse), 1);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule